// File: doc/BRIEF.md
# Multi-Mode Parallel Video Capture Formatter

This block sits behind a parallel video input port and turns its raw bus into a stream of pixels. It runs in the pixel clock domain. The port carries a 24-bit data bus together with horizontal sync, vertical sync, a data-enable strobe and a field-identifier bit. A 2-bit interface-mode input selects one of three packings:

- A full-width mode, where all three colour components arrive in parallel.
- A 16-bit 4:2:2 mode, where luma and chroma use separate byte lanes.
- An 8-bit 4:2:2 mode, where the components share the low byte lane and arrive one after another.

Each captured pixel leaves the block as a triple of 8-bit components with a valid flag. The components are R/G/B or Y/Cb/Cr, depending on the source. The pixel comes with a delayed horizontal sync and with the vertical sync and field ID captured at the start of the line. Downstream logic can therefore separate odd and even fields without watching the raw inputs. In the two 4:2:2 modes, the block holds the latest Cb and Cr values it has received. Every luma sample becomes one pixel that carries those held chroma values. The reserved mode code produces no pixels and sets a flag that stays set until reset.

Top module: `vidcap_fmt`

## Requirements
- R1: With mode 00 and data-enable high, the next cycle shows pix_valid=1, pix_c0=din[23:16], pix_c1=din[15:8] and pix_c2=din[7:0].
- R2: A cycle with data-enable low is ignored. The next cycle shows pix_valid=0, and the component outputs keep their previous values.
- R3: In mode 01, each enabled cycle emits a pixel one cycle later. pix_c0 is the luma from din[15:8]. The chroma byte din[7:0] is taken as Cb and Cr in turn, starting with Cb. din[23:16] has no effect.
- R4: In mode 10, the byte on din[7:0] follows the repeating order Cb, Y, Cr, Y. A pixel is emitted one cycle after each Y byte, and no pixel follows a Cb or Cr byte. din[23:8] has no effect.
- R5: In modes 01 and 10, pix_c1 and pix_c2 are the most recently received Cb and Cr, counting a chroma byte taken in the same cycle. The held values persist across lines and across mode changes, and only reset clears them to 0.
- R6: Mode 11 is reserved. It yields pix_valid=0, and one cycle after mode 11 is seen, mode_err becomes 1 and stays 1 until reset.
- R7: A line starts at an enabled cycle whose preceding cycle had data-enable low. vsync_o and fid_o show the vsync_i and fid_i values from that cycle, starting one cycle later. They hold those values until the next line start.
- R8: hsync_o equals hsync_i delayed by one clock.
- R9: A line start forces the 4:2:2 component phase back to Cb, so every line begins on a Cb sample.
- R10: In mode 00, 16-bit RGB565 data placed at the top of each byte lane (red at 23:19, green at 15:10, blue at 7:3) reaches the outputs with the same bit positions.
- R11: Synchronous active-high reset clears pix_valid, all component outputs, the sync outputs, fid_o, mode_err and the held chroma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Interface packing mode (00 parallel, 01 16-bit 4:2:2, 10 8-bit 4:2:2, 11 reserved) |
| din_i | input | 24 | Raw video data bus |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable; the bus is captured only when high |
| fid_i | input | 1 | Field identifier |
| pix_valid_o | output | 1 | A new pixel is present on the component outputs |
| pix_c0_o | output | 8 | Red or luma |
| pix_c1_o | output | 8 | Green or Cb |
| pix_c2_o | output | 8 | Blue or Cr |
| hsync_o | output | 1 | Horizontal sync, delayed one clock |
| vsync_o | output | 1 | Vertical sync captured at line start |
| fid_o | output | 1 | Field identifier captured at line start |
| mode_err | output | 1 | Sticky flag for the reserved mode |

## Verification
A wrong component phase shows up in the 8-bit mode at the first pixel of a line: its Cb and luma are swapped, or it appears one byte late. Both are visible on the outputs one cycle after the line's second byte. A stale or wrongly loaded chroma hold shows on pix_c1 or pix_c2 of the next pixel that follows the bad load. A line-start detector that fires too often or too seldom shows on fid_o one cycle after the enable edge, or when it fails to hold during the line. The sticky error flag is checked across a later return to a legal mode.

// File: rtl/vidcap_pkg.sv
package vidcap_pkg;

  typedef enum logic [1:0] {
    MODE_PAR24   = 2'b00,
    MODE_SPLIT16 = 2'b01,
    MODE_MUX8    = 2'b10,
    MODE_RSVD    = 2'b11
  } if_mode_e;

  // Whether an enabled sample in this mode/phase produces an output pixel.
  function automatic logic f_emits(if_mode_e m, logic [1:0] ph);
    case (m)
      MODE_PAR24:   f_emits = 1'b1;
      MODE_SPLIT16: f_emits = 1'b1;
      MODE_MUX8:    f_emits = ph[0];
      default:      f_emits = 1'b0;
    endcase
  endfunction

  // Whether the chroma byte of this sample is a Cb.
  function automatic logic f_cb_take(if_mode_e m, logic [1:0] ph);
    case (m)
      MODE_SPLIT16: f_cb_take = ~ph[0];
      MODE_MUX8:    f_cb_take = (ph == 2'd0);
      default:      f_cb_take = 1'b0;
    endcase
  endfunction

  // Whether the chroma byte of this sample is a Cr.
  function automatic logic f_cr_take(if_mode_e m, logic [1:0] ph);
    case (m)
      MODE_SPLIT16: f_cr_take = ph[0];
      MODE_MUX8:    f_cr_take = (ph == 2'd2);
      default:      f_cr_take = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vidcap_phase.sv
module vidcap_phase #(
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            de,
  output logic            line_start,
  output logic [PH_W-1:0] phase
);
  logic            de_q;
  logic [PH_W-1:0] ph_q;

  assign line_start = de & ~de_q;
  assign phase      = line_start ? '0 : ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q <= 1'b0;
      ph_q <= '0;
    end else begin
      de_q <= de;
      if (de) ph_q <= phase + 1'b1;
    end
  end

  // The first sample of a line is taken in phase 0, so the stored phase is 1 afterwards.
  assert_line_start_phase_R9: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (ph_q == PH_W'(1)));

endmodule

// File: rtl/vidcap_lane_sel.sv
module vidcap_lane_sel
  import vidcap_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  if_mode_e          mode,
  input  logic [1:0]        phase,
  input  logic              de,
  input  logic [3*LANE_W-1:0] din,
  input  logic [LANE_W-1:0] cb_hold,
  input  logic [LANE_W-1:0] cr_hold,
  output logic              pix_fire,
  output logic              cb_load,
  output logic              cr_load,
  output logic [LANE_W-1:0] chroma_new,
  output logic [LANE_W-1:0] nxt_c0,
  output logic [LANE_W-1:0] nxt_c1,
  output logic [LANE_W-1:0] nxt_c2
);
  logic [LANE_W-1:0] lane_lo, lane_mid, lane_hi, luma, cb_eff, cr_eff;

  always_comb begin
    lane_lo  = din[LANE_W-1:0];
    lane_mid = din[2*LANE_W-1:LANE_W];
    lane_hi  = din[3*LANE_W-1:2*LANE_W];

    pix_fire = de & f_emits(mode, phase);
    cb_load  = de & f_cb_take(mode, phase);
    cr_load  = de & f_cr_take(mode, phase);
    chroma_new = lane_lo;

    case (mode)
      MODE_PAR24:   luma = lane_hi;
      MODE_SPLIT16: luma = lane_mid;
      default:      luma = lane_lo;
    endcase

    cb_eff = cb_load ? lane_lo : cb_hold;
    cr_eff = cr_load ? lane_lo : cr_hold;

    nxt_c0 = luma;
    nxt_c1 = (mode == MODE_PAR24) ? lane_mid : cb_eff;
    nxt_c2 = (mode == MODE_PAR24) ? lane_lo  : cr_eff;
  end

endmodule

// File: rtl/vidcap_out.sv
module vidcap_out #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_rsvd,
  input  logic              pix_fire,
  input  logic              cb_load,
  input  logic              cr_load,
  input  logic [LANE_W-1:0] chroma_new,
  input  logic [LANE_W-1:0] nxt_c0,
  input  logic [LANE_W-1:0] nxt_c1,
  input  logic [LANE_W-1:0] nxt_c2,
  input  logic              line_start,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              fid_in,
  output logic              valid,
  output logic [LANE_W-1:0] c0,
  output logic [LANE_W-1:0] c1,
  output logic [LANE_W-1:0] c2,
  output logic              hs,
  output logic              vs,
  output logic              fid,
  output logic              err,
  output logic [LANE_W-1:0] cb_hold,
  output logic [LANE_W-1:0] cr_hold
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      c0      <= '0;
      c1      <= '0;
      c2      <= '0;
      hs      <= 1'b0;
      vs      <= 1'b0;
      fid     <= 1'b0;
      err     <= 1'b0;
      cb_hold <= '0;
      cr_hold <= '0;
    end else begin
      hs    <= hsync_in;
      valid <= pix_fire;
      if (line_start) begin
        vs  <= vsync_in;
        fid <= fid_in;
      end
      if (mode_rsvd) err <= 1'b1;
      if (pix_fire) begin
        c0 <= nxt_c0;
        c1 <= nxt_c1;
        c2 <= nxt_c2;
      end
      if (cb_load) cb_hold <= chroma_new;
      if (cr_load) cr_hold <= chroma_new;
    end
  end

  assert_rsvd_no_pixel_R6: assert property (@(posedge clk) disable iff (rst)
    mode_rsvd |=> (!valid && err));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_hsync_delay_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (hs == $past(hsync_in)));

  assert_fid_held_R7: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(fid));

endmodule

// File: rtl/vidcap_fmt.sv
module vidcap_fmt
  import vidcap_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = 3 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic [BUS_W-1:0]  din_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              de_i,
  input  logic              fid_i,
  output logic              pix_valid_o,
  output logic [LANE_W-1:0] pix_c0_o,
  output logic [LANE_W-1:0] pix_c1_o,
  output logic [LANE_W-1:0] pix_c2_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              fid_o,
  output logic              mode_err
);
  if_mode_e          mode_e;
  logic              line_start;
  logic [1:0]        phase;
  logic              pix_fire, cb_load, cr_load;
  logic [LANE_W-1:0] chroma_new, nxt_c0, nxt_c1, nxt_c2, cb_hold, cr_hold;

  assign mode_e = if_mode_e'(mode_i);

  vidcap_phase #(.PH_W(2)) u_phase (
    .clk(clk), .rst(rst), .de(de_i), .line_start(line_start), .phase(phase)
  );

  vidcap_lane_sel #(.LANE_W(LANE_W)) u_sel (
    .mode(mode_e), .phase(phase), .de(de_i), .din(din_i),
    .cb_hold(cb_hold), .cr_hold(cr_hold),
    .pix_fire(pix_fire), .cb_load(cb_load), .cr_load(cr_load),
    .chroma_new(chroma_new), .nxt_c0(nxt_c0), .nxt_c1(nxt_c1), .nxt_c2(nxt_c2)
  );

  vidcap_out #(.LANE_W(LANE_W)) u_out (
    .clk(clk), .rst(rst), .mode_rsvd(mode_e == MODE_RSVD),
    .pix_fire(pix_fire), .cb_load(cb_load), .cr_load(cr_load),
    .chroma_new(chroma_new), .nxt_c0(nxt_c0), .nxt_c1(nxt_c1), .nxt_c2(nxt_c2),
    .line_start(line_start), .hsync_in(hsync_i), .vsync_in(vsync_i), .fid_in(fid_i),
    .valid(pix_valid_o), .c0(pix_c0_o), .c1(pix_c1_o), .c2(pix_c2_o),
    .hs(hsync_o), .vs(vsync_o), .fid(fid_o), .err(mode_err),
    .cb_hold(cb_hold), .cr_hold(cr_hold)
  );

  assert_par24_lanes_R1: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00 && de_i) |=>
      (pix_valid_o && pix_c0_o == $past(din_i[BUS_W-1:2*LANE_W])
                   && pix_c2_o == $past(din_i[LANE_W-1:0])));

  assert_de_low_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    !de_i |=> (!pix_valid_o && $stable(pix_c0_o) && $stable(pix_c1_o)));

endmodule

// File: tb/test_vidcap_fmt.sv
`timescale 1ns/1ps
module test_vidcap_fmt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_i = 2'b00;
  logic [23:0] din_i = '0;
  logic        hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0, fid_i = 1'b0;
  logic        pix_valid_o, hsync_o, vsync_o, fid_o, mode_err;
  logic [7:0]  pix_c0_o, pix_c1_o, pix_c2_o;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  vidcap_fmt i_vidcap_fmt (
    .clk(clk), .rst(rst), .mode_i(mode_i), .din_i(din_i),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i), .fid_i(fid_i),
    .pix_valid_o(pix_valid_o), .pix_c0_o(pix_c0_o), .pix_c1_o(pix_c1_o),
    .pix_c2_o(pix_c2_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .fid_o(fid_o),
    .mode_err(mode_err)
  );

  // {mode, de, din, expected valid, expected c0/c1/c2 (checked when valid)}
  localparam int NV = 20;
  localparam logic [51:0] VEC [NV] = '{
    {2'd0, 1'b1, 24'hA1B2C3, 1'b1, 24'hA1B2C3},  // R1
    {2'd0, 1'b0, 24'h111111, 1'b0, 24'h000000},  // R2
    {2'd0, 1'b1, 24'hF8FCF8, 1'b1, 24'hF8FCF8},  // R10 RGB565 white
    {2'd1, 1'b0, 24'h000000, 1'b0, 24'h000000},  // R2
    {2'd1, 1'b1, 24'hEE8040, 1'b1, 24'h804000},  // R3 Cb first, R5 Cr reset value
    {2'd1, 1'b1, 24'h008250, 1'b1, 24'h824050},  // R3 Cr
    {2'd1, 1'b1, 24'h008460, 1'b1, 24'h846050},  // R3 Cb again
    {2'd1, 1'b0, 24'h000000, 1'b0, 24'h000000},  // R2
    {2'd1, 1'b1, 24'h009070, 1'b1, 24'h907050},  // R9 line restarts on Cb
    {2'd2, 1'b0, 24'h000000, 1'b0, 24'h000000},  // R2
    {2'd2, 1'b1, 24'h000011, 1'b0, 24'h000000},  // R4 Cb, no pixel
    {2'd2, 1'b1, 24'h000022, 1'b1, 24'h221150},  // R4 R5
    {2'd2, 1'b1, 24'h000033, 1'b0, 24'h000000},  // R4 Cr, no pixel
    {2'd2, 1'b1, 24'h000044, 1'b1, 24'h441133},  // R4 R5
    {2'd2, 1'b1, 24'h000055, 1'b0, 24'h000000},  // R4 wrap to Cb
    {2'd2, 1'b1, 24'h000066, 1'b1, 24'h665533},  // R4
    {2'd2, 1'b1, 24'hFFFF77, 1'b0, 24'h000000},  // R4 upper lanes ignored
    {2'd2, 1'b0, 24'h000000, 1'b0, 24'h000000},  // R2
    {2'd2, 1'b1, 24'h000088, 1'b0, 24'h000000},  // R9 restart on Cb
    {2'd2, 1'b1, 24'h000099, 1'b1, 24'h998877}   // R9 R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 valid", {31'd0, pix_valid_o}, 0);
    chk("R11 data", {8'd0, pix_c0_o, pix_c1_o, pix_c2_o}, 0);
    chk("R11 err/fid", {30'd0, mode_err, fid_o}, 0);
    rst = 1'b0;

    // Table walk: drive at a falling edge, check at the next one.
    for (int i = 0; i < NV; i++) begin
      {mode_i, de_i, din_i} = VEC[i][51:25];
      @(negedge clk);
      chk($sformatf("R2/R4 valid vec%0d", i), {31'd0, pix_valid_o}, {31'd0, VEC[i][24]});
      if (VEC[i][24])
        chk($sformatf("R1/R3/R5 data vec%0d", i),
            {8'd0, pix_c0_o, pix_c1_o, pix_c2_o}, {8'd0, VEC[i][23:0]});
    end
    de_i = 1'b0; mode_i = 2'd0;

    // R8: hsync one-cycle delay
    hsync_i = 1'b1;
    @(negedge clk);
    chk("R8 hsync high", {31'd0, hsync_o}, 1);
    hsync_i = 1'b0;
    @(negedge clk);
    chk("R8 hsync low", {31'd0, hsync_o}, 0);

    // R7: vsync/fid captured at line start, then held through the line
    vsync_i = 1'b1; fid_i = 1'b1;
    @(negedge clk);
    chk("R7 no capture while de low", {30'd0, vsync_o, fid_o}, 0);
    de_i = 1'b1; din_i = 24'h010203;
    @(negedge clk);
    chk("R7 captured", {30'd0, vsync_o, fid_o}, 3);
    vsync_i = 1'b0; fid_i = 1'b0;
    @(negedge clk);
    chk("R7 held mid-line", {30'd0, vsync_o, fid_o}, 3);
    de_i = 1'b0;
    @(negedge clk);
    de_i = 1'b1;
    @(negedge clk);
    chk("R7 next line", {30'd0, vsync_o, fid_o}, 0);

    // R6: reserved mode
    mode_i = 2'd3; din_i = 24'h445566;
    @(negedge clk);
    chk("R6 no valid", {31'd0, pix_valid_o}, 0);
    chk("R6 err set", {31'd0, mode_err}, 1);
    mode_i = 2'd0; din_i = 24'h778899;
    @(negedge clk);
    chk("R6 err sticky", {31'd0, mode_err}, 1);
    chk("R1 back to legal", {8'd0, pix_c0_o, pix_c1_o, pix_c2_o}, 32'h00778899);

    // R11: reset clears everything
    rst = 1'b1; de_i = 1'b0;
    @(negedge clk);
    chk("R11 err cleared", {31'd0, mode_err}, 0);
    chk("R11 data cleared", {8'd0, pix_c0_o, pix_c1_o, pix_c2_o}, 0);
    rst = 1'b0;
    // R5: held chroma cleared by reset
    mode_i = 2'd1; de_i = 1'b1; din_i = 24'h00AA00;
    @(negedge clk);
    de_i = 1'b1; din_i = 24'h00BB00;
    @(negedge clk);
    de_i = 1'b0;
    mode_i = 2'd2; 
    @(negedge clk);
    de_i = 1'b1; din_i = 24'h000001;
    @(negedge clk);
    din_i = 24'h000002;
    @(negedge clk);
    chk("R5 Cr after reset", {24'd0, pix_c2_o}, 0);
    de_i = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule